// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. It absorbs single-word stores so the processor can keep going while the slower write to memory is still on its way. Storage is a small ring of entries. Each entry covers one aligned block of words and keeps a valid bit for every word it has collected.

A cacheable store looks for an entry that already holds its block. If one exists and that entry is not the one at the head of the ring, the store is written into it and no new entry is taken. The head entry is the one being offered to memory, so it never takes a merge. A store flagged as an I/O access never merges and always takes an entry of its own. Entries leave in arrival order, one whole block per memory handshake. Each carries a word mask, so memory writes only the words that were stored.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1 and `mem_valid` is 0.
- R2: An accepted store to an empty buffer appears on the memory side on the next cycle. `mem_addr` is the store address with its low 5 bits cleared. `mem_mask` bit k is set only for word k, where the word index is address bits [4:2].
- R3: A cacheable store to a block held by a pending non-head cacheable entry is merged into that entry. It writes its word, sets that word's mask bit and takes no new entry. A later store to the same word replaces the earlier data.
- R4: A store with `st_io` = 1 always takes a new entry. It never merges, and no other store merges into an I/O entry.
- R5: The head entry, the one presented on the memory side, never accepts a merge. A store to its block takes a new entry.
- R6: Entries are written to memory in the order they were allocated, one block per cycle in which `mem_valid` and `mem_ready` are both 1. `mem_valid` is 1 exactly when an entry is pending.
- R7: `st_ready` is 0 only when all entries are in use and the store cannot merge. A mergeable store is accepted even when the buffer is full.
- R8: `mem_mask` has a 1 for each word stored into the entry and 0 for each other word. The corresponding 32-bit lanes of `mem_data` (word k at bits [32k+31:32k]) carry the latest data stored to each word.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_mask` and `mem_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when st_valid is 1 |
| st_addr | input | 32 | Byte address of the store (word aligned) |
| st_data | input | 32 | Store data word |
| st_io | input | 1 | Store targets an I/O address; never merged |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory takes the head entry this cycle |
| mem_addr | output | 32 | Block-aligned address of the head entry |
| mem_data | output | 256 | Eight data words of the head entry |
| mem_mask | output | 8 | Per-word write enables of the head entry |

## Verification
The bench builds the block with its defaults: four entries, eight 32-bit words per block and a 32-bit address. With only four entries, a handful of stores fills the buffer. This makes a full buffer that still accepts a merge, and a full buffer that stalls a new block, easy to reach. Eight word lanes are enough to show a merge into one word, an overwrite of the same word, and mask bits left clear. A phase in which memory readiness is toggled makes merges, allocations and drains fall in the same cycles.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 8,
  parameter int DW      = 32,
  parameter int AW      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  output logic                st_ready,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  input  logic                st_io,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS*DW-1:0] mem_data,
  output logic [WORDS-1:0]    mem_mask
);
  localparam int BSW  = $clog2(DW/8);
  localparam int WSW  = $clog2(WORDS);
  localparam int OFFW = BSW + WSW;
  localparam int TAGW = AW - OFFW;
  localparam int PTRW = $clog2(ENTRIES);
  localparam int CW   = PTRW + 1;

  logic [TAGW-1:0]  tag_q [ENTRIES];
  logic             io_q  [ENTRIES];
  logic [WORDS-1:0] msk_q [ENTRIES];
  logic [DW-1:0]    dat_q [ENTRIES][WORDS];
  logic [ENTRIES-1:0] vld_q;
  logic [PTRW-1:0]  head_q, tail_q;
  logic [CW-1:0]    count_q;

  logic [TAGW-1:0] st_tag;
  logic [WSW-1:0]  widx;
  logic            hit, acc, pop, alloc;
  logic [PTRW-1:0] hit_idx;

  assign st_tag = st_addr[AW-1:OFFW];
  assign widx   = st_addr[BSW +: WSW];

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && !io_q[i] && !st_io && tag_q[i] == st_tag &&
          head_q != PTRW'(i)) begin
        hit     = 1'b1;
        hit_idx = PTRW'(i);
      end
    end
  end

  assign st_ready  = hit || (count_q != CW'(ENTRIES));
  assign acc       = st_valid && st_ready;
  assign alloc     = acc && !hit;
  assign mem_valid = count_q != '0;
  assign pop       = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= tail_q + 1'b1;
      end
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      count_q <= count_q + CW'(alloc) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (acc && hit) begin
      dat_q[hit_idx][widx] <= st_data;
      msk_q[hit_idx][widx] <= 1'b1;
    end else if (alloc) begin
      tag_q[tail_q]        <= st_tag;
      io_q[tail_q]         <= st_io;
      msk_q[tail_q]        <= WORDS'(1) << widx;
      dat_q[tail_q][widx]  <= st_data;
    end
  end

  assign mem_addr = {tag_q[head_q], OFFW'(0)};
  assign mem_mask = msk_q[head_q];

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    assign mem_data[w*DW +: DW] = dat_q[head_q][w];
  end
endmodule

module merge_wbuf_chk #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int ENTRIES = 4,
  parameter int CW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st_valid,
  input logic                st_ready,
  input logic                st_io,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [AW-1:0]       mem_addr,
  input logic [WORDS*DW-1:0] mem_data,
  input logic [WORDS-1:0]    mem_mask,
  input logic [CW-1:0]       cnt
);
  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
    $stable(mem_mask) && $stable(mem_data));

  // R7
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> cnt == CW'(ENTRIES));

  // R8
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_mask != '0);

  // R2
  first_store_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && !mem_valid |=> mem_valid);

  // R4
  io_takes_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_io && !(mem_valid && mem_ready)
    |=> cnt == $past(cnt) + CW'(1));
endmodule

bind merge_wbuf merge_wbuf_chk #(
  .WORDS(WORDS), .DW(DW), .AW(AW), .ENTRIES(ENTRIES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_io(st_io), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask),
  .cnt(count_q)
);

// File: tb/merge_wbuf_test.sv
module merge_wbuf_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         st_valid = 0;
  logic         st_ready;
  logic [31:0]  st_addr = 0;
  logic [31:0]  st_data = 0;
  logic         st_io = 0;
  logic         mem_valid;
  logic         mem_ready = 0;
  logic [31:0]  mem_addr;
  logic [255:0] mem_data;
  logic [7:0]   mem_mask;

  merge_wbuf uut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [26:0]  tag;
    logic         io;
    logic [7:0]   msk;
    logic [255:0] dat;
  } ent_t;

  ent_t q[$];
  int total = 0, bad = 0;
  bit running = 0, done = 0;

  function automatic logic [255:0] lanes(logic [7:0] m);
    logic [255:0] r = '0;
    for (int k = 0; k < 8; k++) if (m[k]) r[k*32 +: 32] = '1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: computes expected acceptance and updates the model
  task automatic store(logic [31:0] a, logic [31:0] d, logic io);
    int idx;
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_io = io;
    forever begin
      #2;
      idx = -1;
      for (int i = 1; i < q.size(); i++)
        if (!io && !q[i].io && q[i].tag == a[31:5]) idx = i;
      // R7 expected ready
      check(st_ready == (idx >= 0 || q.size() < 4), "R7",
            256'(st_ready), 256'(idx >= 0 || q.size() < 4));
      if (st_ready) break;
      @(negedge clk);
    end
    if (idx >= 0) begin
      ent_t e = q[idx];
      e.dat[a[4:2]*32 +: 32] = d;
      e.msk[a[4:2]] = 1'b1;
      q[idx] = e;
    end else begin
      ent_t e = '0;
      e.tag = a[31:5]; e.io = io;
      e.msk[a[4:2]] = 1'b1;
      e.dat[a[4:2]*32 +: 32] = d;
      q.push_back(e);
    end
    @(posedge clk); #1 st_valid = 0;
  endtask

  // monitor: compares memory writes against the model, in order
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        bit take;
        #1;
        check(mem_valid == (q.size() > 0), "R6 valid", 256'(mem_valid), 256'(q.size() > 0));
        take = mem_valid && mem_ready && q.size() > 0;
        if (take) begin
          check(mem_addr == {q[0].tag, 5'd0}, "R6 order/R2 addr",
                256'(mem_addr), 256'({q[0].tag, 5'd0}));
          check(mem_mask == q[0].msk, "R8 mask", 256'(mem_mask), 256'(q[0].msk));
          check((mem_data & lanes(q[0].msk)) == (q[0].dat & lanes(q[0].msk)),
                "R8 data", mem_data & lanes(q[0].msk), q[0].dat & lanes(q[0].msk));
        end
        #2;
        if (take) void'(q.pop_front());
      end
    end
  end

  task automatic drain();
    mem_ready = 1;
    for (int i = 0; i < 200 && q.size() > 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    check(st_ready == 1, "R1 ready", 256'(st_ready), 256'(1));
    check(mem_valid == 0, "R1 valid", 256'(mem_valid), 256'(0));
    running = 1;

    // R2 R5 R3: head not merged, later merges and overwrite
    mem_ready = 0;
    store(32'h1000_0008, 32'hA1, 0);
    store(32'h1000_0008, 32'hB1, 0);   // R5 same block as head -> new entry
    store(32'h1000_0014, 32'hB2, 0);   // R3 merge word 5
    store(32'h1000_0008, 32'hB3, 0);   // R3 overwrite word 2
    store(32'h2000_0000, 32'hC1, 1);   // R4 io entry
    store(32'h2000_0004, 32'hC2, 1);   // R4 io entry, no merge
    store(32'h1000_0000, 32'hB4, 0);   // R7 merge accepted while full
    check(q.size() == 4, "R3 entries", 256'(q.size()), 256'(4));
    fork
      store(32'h3000_0000, 32'hD1, 0); // R7 stalls until a drain
      begin repeat (6) @(negedge clk); mem_ready = 1; end
    join
    drain();

    // R4: cacheable store never joins a pending io entry
    mem_ready = 0;
    store(32'h4000_0000, 32'hE1, 1);
    store(32'h5000_0000, 32'hE2, 1);
    store(32'h5000_0004, 32'hE3, 0);
    check(q.size() == 3, "R4 entries", 256'(q.size()), 256'(3));
    drain();

    // R6 R8 R9: mixed traffic with toggling memory readiness
    fork
      for (int n = 0; n < 40; n++)
        store({4'h6, 23'(n % 3), 5'(((n * 5) % 8) << 2)}, 32'h100 + n, n % 7 == 0);
      for (int c = 0; c < 120; c++) begin
        @(negedge clk); mem_ready = (c % 3 == 1);
      end
    join
    drain();
    running = 0;
    finish_up();
  end
endmodule